// File: doc/BRIEF.md
# Graphics Adapter Aperture Decoder

This block sits between a local processor bus and a graphics controller. From each bus cycle it works out whether the controller is being addressed and drives one of two active-low selects. The memory-aperture select covers the legacy 128 KB video window at 0xA0000, a 4 MB linear framebuffer at a relocatable base, and every I/O port cycle in the low 64 KB. The I/O case is needed because the controller only answers port accesses while that select is active. The register-aperture select covers a 4 MB window placed 16 MB above the framebuffer base.

Board jumpers choose the framebuffer base. A three-bit code picks a power-of-two base between 32 MB and 512 MB, and the default code gives 64 MB. A separate jumper also forces address bit 25 (32 MB) on, which gives offsets such as 96 MB or 544 MB. These keep the aperture clear of system RAM. Every address bit above each window is compared, so no window appears again at a multiple of the base. The active base is also output in 64 KB units, so that a readback register can report it to software.

The decode is captured on the bus clock in the cycle where the address strobe is low. The select then holds until the ready strobe ends the transfer. The 16 address bits below 64 KB never affect a decision, so the bus address enters as bits 31:16.

Top module: `gfx_aperture_dec`

## Requirements
- R1: After reset both `mem_sel_n` and `reg_sel_n` are high (inactive).
- R2: A memory cycle (`cyc_is_mem`=1) to 0xA0000 through 0xBFFFF asserts `mem_sel_n`; 0x9FFFF and 0xC0000 assert nothing.
- R3: A memory cycle from the base to base+0x3FFFFF asserts `mem_sel_n`; base+0x400000 does not.
- R4: A memory cycle from base+0x1000000 to base+0x13FFFFF asserts `reg_sel_n` only; base+0x1400000 asserts nothing; the two selects are never low together, and the register aperture takes priority.
- R5: `base_code` maps 0 to 64 MB, 1 to 32 MB, 2 to 128 MB, 3 to 256 MB and 4 to 512 MB; codes 5 to 7 fall back to 64 MB.
- R6: With `base_alt`=1 the base is the coded base with bit 25 (32 MB) also set, e.g. code 0 gives 96 MB and code 4 gives 544 MB; both windows move with it.
- R7: The framebuffer does not mirror: with a 64 MB base, memory cycles to 128 MB, 192 MB, 384 MB and 2 GB+64 MB assert nothing.
- R8: An I/O cycle (`cyc_is_mem`=0) with `io_strobe_n` low and an address of 0xFFFF or below asserts `mem_sel_n`; at 0x10000 or above it asserts nothing.
- R9: An I/O cycle with `io_strobe_n` high asserts neither select, whatever its address.
- R10: A memory cycle outside all three windows asserts neither select, whatever the level of `io_strobe_n`.
- R11: The selects take the decoded value at the clock edge where `addr_strobe_n` is sampled low, hold it while both strobes are high, and both go high at the edge where `ready_n` is sampled low.
- R12: `base_units` equals the active base divided by 64 KB and follows the jumper inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Bus address bits 31:16 |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| io_strobe_n | input | 1 | Active-low I/O strobe from the bus |
| addr_strobe_n | input | 1 | Active-low address strobe, starts a cycle |
| ready_n | input | 1 | Active-low cycle-ready, ends a transfer |
| base_code | input | 3 | Jumper code choosing the framebuffer base |
| base_alt | input | 1 | Jumper that forces the 32 MB address bit |
| mem_sel_n | output | 1 | Active-low memory-aperture select |
| reg_sel_n | output | 1 | Active-low register-aperture select |
| base_units | output | 16 | Active base in 64 KB units |

## Verification
The assertions assume that the address, the cycle type and the I/O strobe are stable and defined at the clock edge where `addr_strobe_n` is low. They also assume that the jumper inputs change only while no transfer is open. The stimulus drives every input on the falling edge. It moves the jumpers only between transfers, and it closes each transfer with `ready_n` before the next address strobe, so the hold and clear checks always see a single open transfer.

// File: rtl/gfx_dec_pkg.sv
package gfx_dec_pkg;

   localparam int CODE_BITS   = 3;
   localparam int DEF_LOG2    = 26;

   typedef enum logic [CODE_BITS-1:0] {
      BASE_64M  = 3'd0,
      BASE_32M  = 3'd1,
      BASE_128M = 3'd2,
      BASE_256M = 3'd3,
      BASE_512M = 3'd4
   } base_code_e;

   typedef enum int {
      WIN_LEGACY = 0,
      WIN_FB     = 1,
      WIN_REGS   = 2
   } win_id_e;

   localparam int NUM_WIN = 3;

   typedef struct packed {
      logic mem_hit;
      logic regs_hit;
   } dec_hit_t;

   function automatic int unsigned base_log2(input int unsigned code);
      case (code)
         32'(BASE_32M):  return 25;
         32'(BASE_64M):  return 26;
         32'(BASE_128M): return 27;
         32'(BASE_256M): return 28;
         32'(BASE_512M): return 29;
         default:        return DEF_LOG2;
      endcase
   endfunction

endpackage

// File: rtl/gfx_base_select.sv
module gfx_base_select #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_LOG2 = 16,
   parameter int CODE_W    = 3,
   parameter int ALT_LOG2  = 25
) (
   input  logic [CODE_W-1:0]           base_code,
   input  logic                        base_alt,
   output logic [ADDR_W-PAGE_LOG2-1:0] base_pg
);
   localparam int PG_W = ADDR_W - PAGE_LOG2;
   localparam logic [PG_W-1:0] ALT_MASK = PG_W'(1) << (ALT_LOG2 - PAGE_LOG2);

   generate
      if (CODE_W != gfx_dec_pkg::CODE_BITS) begin : g_bad_code
         $error("gfx_base_select: CODE_W must match the package code width");
      end
      if (ALT_LOG2 <= PAGE_LOG2) begin : g_bad_alt
         $error("gfx_base_select: forced bit must lie above the page size");
      end
   endgenerate

   logic [PG_W-1:0] raw_pg;
   int unsigned     shift_pg;

   always_comb begin
      shift_pg = gfx_dec_pkg::base_log2(32'(base_code)) - PAGE_LOG2;
      raw_pg   = PG_W'(1) << shift_pg;
      base_pg  = base_alt ? (raw_pg | ALT_MASK) : raw_pg;
   end

endmodule

// File: rtl/gfx_window_match.sv
module gfx_window_match #(
   parameter int TAG_W = 10
) (
   input  logic [TAG_W-1:0] addr_tag,
   input  logic [TAG_W-1:0] base_tag,
   output logic             hit
);
   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("gfx_window_match: tag must be at least one bit");
      end
   endgenerate

   always_comb hit = (addr_tag == base_tag);

endmodule

// File: rtl/gfx_sel_reg.sv
module gfx_sel_reg (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  addr_strobe_n,
   input  logic                  ready_n,
   input  gfx_dec_pkg::dec_hit_t hit,
   output logic                  mem_sel_n,
   output logic                  reg_sel_n
);
   logic mem_next;

   always_comb mem_next = hit.mem_hit & ~hit.regs_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_sel_n <= 1'b1;
         reg_sel_n <= 1'b1;
      end else if (!addr_strobe_n) begin
         mem_sel_n <= ~mem_next;
         reg_sel_n <= ~hit.regs_hit;
      end else if (!ready_n) begin
         mem_sel_n <= 1'b1;
         reg_sel_n <= 1'b1;
      end
   end

   AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_sel_n == 1'b0 && reg_sel_n == 1'b0)); // R4
   AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe_n && !ready_n) |=> (mem_sel_n && reg_sel_n)); // R11
   AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe_n && ready_n) |=> ($stable(mem_sel_n) && $stable(reg_sel_n))); // R11
   AST_REG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe_n && hit.regs_hit) |=> (!reg_sel_n && mem_sel_n)); // R4

endmodule

// File: rtl/gfx_aperture_dec.sv
module gfx_aperture_dec #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_LOG2   = 16,
   parameter int CODE_W      = 3,
   parameter int ALT_LOG2    = 25,
   parameter int FB_LOG2     = 22,
   parameter int REG_OFS_LOG2 = 24,
   parameter int LEGACY_LOG2 = 17,
   parameter logic [31:0] LEGACY_BASE = 32'h000A_0000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:PAGE_LOG2]   bus_addr,
   input  logic                        cyc_is_mem,
   input  logic                        io_strobe_n,
   input  logic                        addr_strobe_n,
   input  logic                        ready_n,
   input  logic [CODE_W-1:0]           base_code,
   input  logic                        base_alt,
   output logic                        mem_sel_n,
   output logic                        reg_sel_n,
   output logic [ADDR_W-PAGE_LOG2-1:0] base_units
);
   import gfx_dec_pkg::*;

   localparam int PG_W     = ADDR_W - PAGE_LOG2;
   localparam int FB_TAG_W = ADDR_W - FB_LOG2;
   localparam int LG_TAG_W = ADDR_W - LEGACY_LOG2;
   localparam logic [LG_TAG_W-1:0] LEG_TAG  = LG_TAG_W'(LEGACY_BASE >> LEGACY_LOG2);
   localparam logic [FB_TAG_W-1:0] REG_STEP = FB_TAG_W'(1) << (REG_OFS_LOG2 - FB_LOG2);
   localparam int ALT_PG   = ALT_LOG2 - PAGE_LOG2;

   generate
      if (FB_LOG2 >= REG_OFS_LOG2) begin : g_bad_overlap
         $error("gfx_aperture_dec: register offset must exceed framebuffer span");
      end
      if (ADDR_W < 31) begin : g_bad_width
         $error("gfx_aperture_dec: address too narrow for the largest base");
      end
      if (LEGACY_LOG2 <= PAGE_LOG2 || FB_LOG2 <= PAGE_LOG2) begin : g_bad_page
         $error("gfx_aperture_dec: windows must be larger than the page size");
      end
      if (ALT_LOG2 < FB_LOG2) begin : g_bad_alt
         $error("gfx_aperture_dec: forced bit must lie above framebuffer span");
      end
   endgenerate

   logic [PG_W-1:0]     base_pg;
   logic [FB_TAG_W-1:0] reg_tag;
   logic [NUM_WIN-1:0]  win_hit;
   logic                io_hit;
   dec_hit_t            hit;

   gfx_base_select #(
      .ADDR_W   (ADDR_W),
      .PAGE_LOG2(PAGE_LOG2),
      .CODE_W   (CODE_W),
      .ALT_LOG2 (ALT_LOG2)
   ) u_base (
      .base_code(base_code),
      .base_alt (base_alt),
      .base_pg  (base_pg)
   );

   always_comb reg_tag = base_pg[PG_W-1:FB_LOG2-PAGE_LOG2] + REG_STEP;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      if (w == WIN_LEGACY) begin : g_legacy
         gfx_window_match #(.TAG_W(LG_TAG_W)) u_match (
            .addr_tag(bus_addr[ADDR_W-1:LEGACY_LOG2]),
            .base_tag(LEG_TAG),
            .hit     (win_hit[w])
         );
      end else if (w == WIN_FB) begin : g_fb
         gfx_window_match #(.TAG_W(FB_TAG_W)) u_match (
            .addr_tag(bus_addr[ADDR_W-1:FB_LOG2]),
            .base_tag(base_pg[PG_W-1:FB_LOG2-PAGE_LOG2]),
            .hit     (win_hit[w])
         );
      end else begin : g_regs
         gfx_window_match #(.TAG_W(FB_TAG_W)) u_match (
            .addr_tag(bus_addr[ADDR_W-1:FB_LOG2]),
            .base_tag(reg_tag),
            .hit     (win_hit[w])
         );
      end
   end

   always_comb begin
      io_hit       = !cyc_is_mem && !io_strobe_n && (bus_addr == '0);
      hit.mem_hit  = (cyc_is_mem && (win_hit[WIN_LEGACY] || win_hit[WIN_FB])) || io_hit;
      hit.regs_hit = cyc_is_mem && win_hit[WIN_REGS];
   end

   gfx_sel_reg u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_strobe_n(addr_strobe_n),
      .ready_n      (ready_n),
      .hit          (hit),
      .mem_sel_n    (mem_sel_n),
      .reg_sel_n    (reg_sel_n)
   );

   assign base_units = base_pg;

   AST_IO_HIGH_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe_n && !cyc_is_mem && bus_addr != '0) |=> (mem_sel_n && reg_sel_n)); // R8
   AST_IO_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe_n && !cyc_is_mem && io_strobe_n) |=> (mem_sel_n && reg_sel_n)); // R9
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      base_units[ALT_PG-1:0] == '0); // R5
   AST_ALT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      base_alt |-> base_units[ALT_PG]); // R6
   AST_BASE_ONE_OR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(base_units) == 1) || (base_alt && $countones(base_units) == 2)); // R12

endmodule

// File: tb/sim_gfx_aperture_dec.sv
module sim_gfx_aperture_dec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        cyc_is_mem = 1'b1;
   logic        io_strobe_n = 1'b1;
   logic        addr_strobe_n = 1'b1;
   logic        ready_n = 1'b1;
   logic [2:0]  base_code = 3'd0;
   logic        base_alt = 1'b0;
   logic        mem_sel_n;
   logic        reg_sel_n;
   logic [15:0] base_units;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      string tag;
      logic  mem_n;
      logic  reg_n;
   } item_t;

   item_t sb_q[$];

   always #5 clk = ~clk;

   gfx_aperture_dec u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .cyc_is_mem   (cyc_is_mem),
      .io_strobe_n  (io_strobe_n),
      .addr_strobe_n(addr_strobe_n),
      .ready_n      (ready_n),
      .base_code    (base_code),
      .base_alt     (base_alt),
      .mem_sel_n    (mem_sel_n),
      .reg_sel_n    (reg_sel_n),
      .base_units   (base_units)
   );

   task automatic check_sel(string tag, logic em, logic er);
      n_tests++;
      if (mem_sel_n !== em || reg_sel_n !== er) begin
         n_fail++;
         $display("FAIL %s: mem_sel_n/reg_sel_n = %b/%b expected %b/%b",
                  tag, mem_sel_n, reg_sel_n, em, er);
      end
   endtask

   task automatic check_base(string tag, logic [15:0] exp);
      n_tests++;
      if (base_units !== exp) begin
         n_fail++;
         $display("FAIL %s: base_units = %h expected %h", tag, base_units, exp);
      end
   endtask

   // monitor: compares scoreboard items against the selects away from the edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check_sel(it.tag, it.mem_n, it.reg_n);
      end
   end

   // driver: one full transfer; pushes the loaded, held and cleared expectations (R11)
   task automatic run_cycle(string tag, logic [31:0] addr, logic is_mem, logic ion,
                            logic em, logic er);
      @(negedge clk);
      bus_addr      = addr[31:16];
      cyc_is_mem    = is_mem;
      io_strobe_n   = ion;
      addr_strobe_n = 1'b0;
      ready_n       = 1'b1;
      @(posedge clk);
      #1 sb_q.push_back('{tag, em, er});
      @(negedge clk);
      addr_strobe_n = 1'b0 ^ 1'b1;
      @(posedge clk);
      #1 sb_q.push_back('{{tag, " R11 hold"}, em, er});
      @(negedge clk);
      ready_n = 1'b0;
      @(posedge clk);
      #1 sb_q.push_back('{{tag, " R11 clear"}, 1'b1, 1'b1});
      @(negedge clk);
      ready_n     = 1'b1;
      io_strobe_n = 1'b1;
   endtask

   task automatic set_base(logic [2:0] code, logic alt);
      @(negedge clk);
      base_code = code;
      base_alt  = alt;
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_sel("R1 reset idle", 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check_sel("R1 after release", 1'b1, 1'b1);

      // R5 / R12 base codes
      set_base(3'd0, 1'b0); check_base("R5 R12 code0 64MB", 16'h0400);
      set_base(3'd1, 1'b0); check_base("R5 code1 32MB",     16'h0200);
      set_base(3'd2, 1'b0); check_base("R5 code2 128MB",    16'h0800);
      set_base(3'd3, 1'b0); check_base("R5 code3 256MB",    16'h1000);
      set_base(3'd4, 1'b0); check_base("R5 code4 512MB",    16'h2000);
      set_base(3'd5, 1'b0); check_base("R5 code5 default",  16'h0400);
      set_base(3'd7, 1'b0); check_base("R5 code7 default",  16'h0400);
      // R6 forced 32 MB bit
      set_base(3'd0, 1'b1); check_base("R6 alt 96MB",       16'h0600);
      set_base(3'd1, 1'b1); check_base("R6 alt 32MB",       16'h0200);
      set_base(3'd2, 1'b1); check_base("R6 alt 160MB",      16'h0A00);
      set_base(3'd4, 1'b1); check_base("R6 alt 544MB",      16'h2200);

      // base 64 MB
      set_base(3'd0, 1'b0);
      run_cycle("R2 legacy low",   32'h000A_0000, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R2 legacy high",  32'h000B_FFFF, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R2 below legacy", 32'h0009_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R2 above legacy", 32'h000C_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R3 fb start",     32'h0400_0000, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R3 fb end",       32'h043F_FFFF, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R3 fb past",      32'h0440_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R4 reg start",    32'h0500_0000, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle("R4 reg end",      32'h053F_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle("R4 reg past",     32'h0540_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R7 mirror 128MB", 32'h0800_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R7 mirror 192MB", 32'h0C00_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R7 mirror 384MB", 32'h1800_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R7 mirror 2G+64", 32'h8400_0000, 1'b1, 1'b1, 1'b1, 1'b1);
      run_cycle("R8 io 3C0",       32'h0000_03C0, 1'b0, 1'b0, 1'b0, 1'b1);
      run_cycle("R8 io FFFF",      32'h0000_FFFF, 1'b0, 1'b0, 1'b0, 1'b1);
      run_cycle("R8 io 10000",     32'h0001_0000, 1'b0, 1'b0, 1'b1, 1'b1);
      run_cycle("R9 io idle 3C0",  32'h0000_03C0, 1'b0, 1'b1, 1'b1, 1'b1);
      run_cycle("R9 io idle A0000",32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b1);
      run_cycle("R10 mem 3C0",     32'h0000_03C0, 1'b1, 1'b0, 1'b1, 1'b1);
      run_cycle("R10 mem 63MB",    32'h03FF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);

      // R6 moved windows at 544 MB
      set_base(3'd4, 1'b1);
      run_cycle("R6 fb 544MB",     32'h2200_0000, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R6 reg 560MB",    32'h2300_0000, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle("R6 plain 512MB",  32'h2000_0000, 1'b1, 1'b1, 1'b1, 1'b1);

      // R5 windows at 32 MB
      set_base(3'd1, 1'b0);
      run_cycle("R5 fb 32MB",      32'h0200_0000, 1'b1, 1'b1, 1'b0, 1'b1);
      run_cycle("R5 reg 48MB",     32'h0300_0000, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle("R5 old 64MB",     32'h0400_0000, 1'b1, 1'b1, 1'b1, 1'b1);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule